// File: doc/BRIEF.md
# Indirect Statistics Counter Bank

A bank of 32-bit event counters for transmit and receive statistics. The MAC datapath raises one strobe per counter whenever a countable event happens. Each strobe adds one to its counter. A host reaches the counters through a small synchronous register port. A control register sets a counter address and a transfer direction. A data register then reads or loads the selected counter, and the address steps forward after each access. This lets software sweep the whole bank with back-to-back data accesses.

Each counter that wraps from all ones to zero sets its own bit in a transmit or receive rollover flag register. A read of a flag register clears it. Per-bit mask registers decide which flags drive the single interrupt output.

A freeze control holds every counter steady so that software can take a consistent snapshot. Events that arrive while the bank is frozen are not lost. Each cycle's strobes go into a small queue, and the queue is replayed one entry per cycle once freeze is released.

Top module: `stat_counter_bank`

## Requirements
- R1: Register select values are 0 control, 1 data, 2 transmit flags, 3 receive flags, 4 transmit mask and 5 receive mask. Other selects read zero. The control register holds the counter address in bits 5:0, the direction in bit 8 (0 = read mode, 1 = write mode) and freeze in bit 9. Bit 16 is a read-only overflow indication. All other bits read zero, and the register resets to zero.
- R2: In read mode, a read of the data register returns the counter at the current address. The address then advances by one and wraps modulo 64.
- R3: In write mode, a write of the data register loads the counter at the current address and advances the address. A data write in read mode is ignored and leaves the address unchanged. A data read in write mode returns the counter without advancing the address.
- R4: Addresses 0 to 14 select the transmit counters and addresses 16 to 37 select the receive counters. Any other address reads zero, ignores writes, and still advances the address on access.
- R5: Outside freeze and replay, each strobe adds one to its counter in the following cycle. Any number of counters may step in the same cycle.
- R6: When a host load and an event hit the same counter in the same cycle, the counter takes the loaded value plus one.
- R7: A counter steps from all ones to zero. On that same clock edge, the flag bit whose index equals the counter's position within its group is set: the address for transmit counters, or the address minus 16 for receive counters.
- R8: A read of a flag register returns its contents and clears it. A flag raised in the same cycle as the read is kept.
- R9: The interrupt output is high when any flag bit is set together with its mask bit. Masked-off flags are still set and cleared as usual.
- R10: While freeze is set, counters change only by host loads. Each cycle with any strobe is queued. After release, the queue applies one entry per cycle in arrival order, and strobes that arrive during the replay queue behind it.
- R11: The queue holds 16 entries. A strobe cycle that finds it full, with no entry leaving, is dropped and sets the overflow bit, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 3 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational from the select and current state |
| tx_evt | input | 15 | Transmit event strobes, one per counter |
| rx_evt | input | 22 | Receive event strobes, one per counter |
| irq_o | output | 1 | Masked rollover interrupt |

## Verification
The bench preloads counters a few counts below all ones and then drives random strobes. A design that raises the flag one cycle late, or sets the wrong bit index for the receive group, then fails the flag reads and the interrupt checks. Directed cases hit a load colliding with an event, which should give the value plus one rather than losing the event. Other directed cases hit a flag read in the same cycle as a wrap, and data accesses in the wrong direction, where a faulty design would advance the address or load the counter. Freeze bursts longer than the queue check the replay order, the order of live strobes behind the replay, and the sticky overflow. A design that counted during freeze or dropped queued cycles ends with counter values off from the model.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned CNT_W = 32;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_DATA = 3'd1;
  localparam logic [2:0] SEL_TXF  = 3'd2;
  localparam logic [2:0] SEL_RXF  = 3'd3;
  localparam logic [2:0] SEL_TXM  = 3'd4;
  localparam logic [2:0] SEL_RXM  = 3'd5;

  function automatic cnt_t bump(input cnt_t b);
    return b + cnt_t'(1);
  endfunction

  function automatic logic wraps(input cnt_t b);
    return &b;
  endfunction
endpackage

// File: rtl/stat_evt_fifo.sv
module stat_evt_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned NW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [NW-1:0] count;
  logic          full, take;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (count == NW'(DEPTH));
  assign empty = (count == '0);
  assign take  = push && (!full || pop);
  assign ovf   = push && full && !pop;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (take) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({take, pop})
        2'b10:   count <= count + NW'(1);
        2'b01:   count <= count - NW'(1);
        default: count <= count;
      endcase
    end
  end

  // R11
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));
  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/stat_cnt_array.sv
module stat_cnt_array
  import stat_pkg::*;
#(
  parameter int unsigned NUM = 37,
  parameter int unsigned IW  = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0]            inc,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  cnt_t                      wr_val,
  output logic [NUM-1:0][CNT_W-1:0] cnt_q,
  output logic [NUM-1:0]            wrap
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    cnt_t val_q, base;
    assign base     = (wr_en && wr_idx == IW'(g)) ? wr_val : val_q;
    assign wrap[g]  = inc[g] && wraps(base);
    assign cnt_q[g] = val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (inc[g]) val_q <= bump(base);
      else             val_q <= base;
    end

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[g] |=> (val_q == '0));
  end
endmodule

// File: rtl/stat_flag_reg.sv
module stat_flag_reg #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         rd_clr,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] mask,
  output logic         irq_any
);
  assign irq_any = |(flags & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (rd_clr ? '0 : flags) | set;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && (set == '0) |=> (flags == '0));
  // R7
  set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_pkg::*;
#(
  parameter int unsigned NTX        = 15,
  parameter int unsigned NRX        = 22,
  parameter int unsigned RX_BASE    = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned AW         = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     host_sel,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [31:0]    host_wdata,
  output logic [31:0]    host_rdata,
  input  logic [NTX-1:0] tx_evt,
  input  logic [NRX-1:0] rx_evt,
  output logic           irq_o
);
  localparam int unsigned NT = NTX + NRX;
  localparam int unsigned IW = $clog2(NT);

  logic [AW-1:0] addr_q;
  logic          dir_q, frz_q, ovf_q;

  function automatic logic addr_ok(input logic [AW-1:0] a);
    int ai;
    ai = int'(a);
    return (ai < int'(NTX)) || (ai >= int'(RX_BASE) && ai < int'(RX_BASE + NRX));
  endfunction

  function automatic logic [IW-1:0] addr_idx(input logic [AW-1:0] a);
    int ai;
    ai = int'(a);
    return (ai < int'(NTX)) ? IW'(ai) : IW'(ai - int'(RX_BASE) + int'(NTX));
  endfunction

  // host decode
  logic ctrl_wr, data_wr_acc, data_rd_acc, data_acc, cnt_wr_en;
  assign ctrl_wr     = host_wr && host_sel == SEL_CTRL;
  assign data_wr_acc = host_wr && host_sel == SEL_DATA && dir_q;
  assign data_rd_acc = host_rd && host_sel == SEL_DATA && !dir_q;
  assign data_acc    = data_wr_acc || data_rd_acc;
  assign cnt_wr_en   = data_wr_acc && addr_ok(addr_q);

  // event path: live, queued, applied
  logic [NT-1:0] live, fifo_head, apply;
  logic          fifo_empty, fifo_push, fifo_pop, fifo_ovf;
  assign live      = {rx_evt, tx_evt};
  assign fifo_pop  = !frz_q && !fifo_empty;
  assign fifo_push = (frz_q || !fifo_empty) && (live != '0);
  assign apply     = frz_q ? '0 : (fifo_empty ? live : fifo_head);

  stat_evt_fifo #(.W(NT), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n,
    .push(fifo_push), .pop(fifo_pop), .din(live),
    .dout(fifo_head), .empty(fifo_empty), .ovf(fifo_ovf)
  );

  logic [NT-1:0][CNT_W-1:0] cnt_q;
  logic [NT-1:0]            wrap;

  stat_cnt_array #(.NUM(NT), .IW(IW)) u_cnt (
    .clk, .rst_n,
    .inc(apply), .wr_en(cnt_wr_en), .wr_idx(addr_idx(addr_q)),
    .wr_val(host_wdata), .cnt_q, .wrap
  );

  logic [NTX-1:0] txf, txm;
  logic [NRX-1:0] rxf, rxm;
  logic           tx_any, rx_any;

  stat_flag_reg #(.W(NTX)) u_txf (
    .clk, .rst_n, .set(wrap[NTX-1:0]),
    .rd_clr(host_rd && host_sel == SEL_TXF),
    .mask_wr(host_wr && host_sel == SEL_TXM), .mask_wdata(host_wdata[NTX-1:0]),
    .flags(txf), .mask(txm), .irq_any(tx_any)
  );

  stat_flag_reg #(.W(NRX)) u_rxf (
    .clk, .rst_n, .set(wrap[NT-1:NTX]),
    .rd_clr(host_rd && host_sel == SEL_RXF),
    .mask_wr(host_wr && host_sel == SEL_RXM), .mask_wdata(host_wdata[NRX-1:0]),
    .flags(rxf), .mask(rxm), .irq_any(rx_any)
  );

  assign irq_o = tx_any || rx_any;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
      frz_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        addr_q <= host_wdata[AW-1:0];
        dir_q  <= host_wdata[8];
        frz_q  <= host_wdata[9];
      end else if (data_acc) begin
        addr_q <= addr_q + AW'(1);
      end
      ovf_q <= ovf_q || fifo_ovf;
    end
  end

  // read mux
  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_CTRL: begin
        host_rdata[AW-1:0] = addr_q;
        host_rdata[8]      = dir_q;
        host_rdata[9]      = frz_q;
        host_rdata[16]     = ovf_q;
      end
      SEL_DATA: host_rdata = addr_ok(addr_q) ? cnt_q[addr_idx(addr_q)] : '0;
      SEL_TXF:  host_rdata = 32'(txf);
      SEL_RXF:  host_rdata = 32'(rxf);
      SEL_TXM:  host_rdata = 32'(txm);
      SEL_RXM:  host_rdata = 32'(rxm);
      default:  host_rdata = '0;
    endcase
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (addr_q == $past(addr_q) + AW'(1)));
  // R10
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && !cnt_wr_en |=> $stable(cnt_q));
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R3
  wrong_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == SEL_DATA && !dir_q |=> $stable(addr_q) && $stable(cnt_q) || $past(live) != '0 || $past(fifo_pop));
endmodule

// File: tb/stat_counter_bank_test.sv
module stat_counter_bank_test;
  localparam int NTX = 15, NRX = 22, RXB = 16, DEPTH = 16, NT = NTX + NRX;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic           clk = 1'b0, rst_n = 1'b0;
  logic [2:0]     sel_r = '0;
  logic           wr_r = 1'b0, rd_r = 1'b0;
  logic [31:0]    wd_r = '0, host_rdata;
  logic [NTX-1:0] tx_r = '0;
  logic [NRX-1:0] rx_r = '0;
  logic           irq_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stat_counter_bank uut (
    .clk, .rst_n, .host_sel(sel_r), .host_wr(wr_r), .host_rd(rd_r),
    .host_wdata(wd_r), .host_rdata, .tx_evt(tx_r), .rx_evt(rx_r), .irq_o
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference model
  logic [31:0]    mcnt [NT];
  logic [NTX-1:0] mtxf = '0, mtxm = '0;
  logic [NRX-1:0] mrxf = '0, mrxm = '0;
  logic [5:0]     maddr = '0;
  logic           mdir = 0, mfrz = 0, movf = 0;
  logic [NT-1:0]  mq [$];

  function automatic int idx_of(input logic [5:0] a);
    if (int'(a) < NTX) return int'(a);
    if (int'(a) >= RXB && int'(a) < RXB + NRX) return int'(a) - RXB + NTX;
    return -1;
  endfunction

  function automatic logic [31:0] mread(input logic [2:0] s);
    int i;
    case (s)
      3'd0: return {15'b0, movf, 6'b0, mfrz, mdir, 2'b0, maddr};
      3'd1: begin i = idx_of(maddr); return (i < 0) ? 32'h0 : mcnt[i]; end
      3'd2: return 32'(mtxf);
      3'd3: return 32'(mrxf);
      3'd4: return 32'(mtxm);
      3'd5: return 32'(mrxm);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic mirq();
    return ((mtxf & mtxm) != '0) || ((mrxf & mrxm) != '0);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mupdate(input logic [2:0] s, input logic wr, input logic rd,
                         input logic [31:0] wd, input logic [NT-1:0] live);
    logic [NT-1:0] app;
    logic pop, push;
    int wi;
    logic [31:0] base;
    app  = mfrz ? '0 : ((mq.size() == 0) ? live : mq[0]);
    pop  = !mfrz && mq.size() != 0;
    push = (mfrz || mq.size() != 0) && (live != '0);
    wi   = (wr && s == 3'd1 && mdir) ? idx_of(maddr) : -1;
    if (rd && s == 3'd2) mtxf = '0;
    if (rd && s == 3'd3) mrxf = '0;
    for (int k = 0; k < NT; k++) begin
      base = (k == wi) ? wd : mcnt[k];
      if (app[k]) begin
        if (base == 32'hFFFF_FFFF) begin
          if (k < NTX) mtxf[k] = 1'b1; else mrxf[k-NTX] = 1'b1;
        end
        mcnt[k] = base + 32'd1;
      end else mcnt[k] = base;
    end
    if (wr && s == 3'd4) mtxm = wd[NTX-1:0];
    if (wr && s == 3'd5) mrxm = wd[NRX-1:0];
    if (s == 3'd1 && ((wr && mdir) || (rd && !mdir))) maddr = maddr + 6'd1;
    if (wr && s == 3'd0) begin maddr = wd[5:0]; mdir = wd[8]; mfrz = wd[9]; end
    if (pop) void'(mq.pop_front());
    if (push) begin
      if (mq.size() < DEPTH) mq.push_back(live); else movf = 1'b1;
    end
  endtask

  task automatic step(input logic [2:0] s, input logic wr, input logic rd, input logic [31:0] wd,
                      input logic [NTX-1:0] te, input logic [NRX-1:0] re, input string tag);
    sel_r = s; wr_r = wr; rd_r = rd; wd_r = wd; tx_r = te; rx_r = re;
    #1;
    if (rd) chk(host_rdata, mread(s), tag);
    mupdate(s, wr, rd, wd, {re, te});
    @(posedge clk);
    @(negedge clk);
    chk({31'b0, irq_o}, {31'b0, mirq()}, "R9 irq");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 0, 0, 0, '0, '0, "");
  endtask

  task automatic rd_all(input logic frz, input string tag);
    step(3'd0, 1, 0, {22'b0, frz, 1'b0, 8'd0}, '0, '0, "");
    for (int i = 0; i < 64; i++) step(3'd1, 0, 1, 0, '0, '0, tag);
    step(3'd0, 0, 1, 0, '0, '0, "R2 addr wrap");
  endtask

  task automatic rand_ev(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(3'd0, 0, 0, 0, NTX'($urandom & $urandom), NRX'($urandom & $urandom), tag);
  endtask

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int k = 0; k < NT; k++) mcnt[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk({31'b0, irq_o}, 32'h0, "R9 reset irq");
    step(3'd0, 0, 1, 0, '0, '0, "R1 reset ctrl");
    step(3'd2, 0, 1, 0, '0, '0, "R8 reset flags");
    step(3'd6, 0, 1, 0, '0, '0, "R1 unused select");
    // control readback
    step(3'd0, 1, 0, 32'hFFFF_FD25, '0, '0, "");
    step(3'd0, 0, 1, 0, '0, '0, "R1 ctrl fields");
    // sequential loads across the map, then sweep
    step(3'd0, 1, 0, 32'h0000_0100, '0, '0, "");
    for (int i = 0; i < 40; i++) step(3'd1, 1, 0, 32'h1000 + i * 3, '0, '0, "");
    step(3'd0, 0, 1, 0, '0, '0, "R3 write advance");
    rd_all(0, "R4 map");
    // wrong-direction accesses
    step(3'd0, 1, 0, 32'h0000_0002, '0, '0, "");
    step(3'd1, 1, 0, 32'h0000_1234, '0, '0, "");
    step(3'd0, 0, 1, 0, '0, '0, "R3 ignored write addr");
    step(3'd1, 0, 1, 0, '0, '0, "R3 ignored write value");
    step(3'd0, 1, 0, 32'h0000_0104, '0, '0, "");
    step(3'd1, 0, 1, 0, '0, '0, "R3 read in write mode");
    step(3'd0, 0, 1, 0, '0, '0, "R3 no advance");
    // collision
    step(3'd0, 1, 0, 32'h0000_0103, '0, '0, "");
    step(3'd1, 1, 0, 32'd100, NTX'(8), '0, "");
    step(3'd0, 1, 0, 32'h0000_0003, '0, '0, "");
    step(3'd1, 0, 1, 0, '0, '0, "R6 load plus one");
    // flag read in the same cycle as a wrap
    step(3'd0, 1, 0, 32'h0000_0100, '0, '0, "");
    step(3'd1, 1, 0, 32'hFFFF_FFFF, '0, '0, "");
    step(3'd2, 0, 1, 0, NTX'(1), '0, "R8 read before set");
    step(3'd2, 0, 1, 0, '0, '0, "R8 same-cycle set kept");
    step(3'd2, 0, 1, 0, '0, '0, "R8 cleared");
    // preload near wrap, random traffic with masks
    step(3'd0, 1, 0, 32'h0000_0100, '0, '0, "");
    for (int i = 0; i < 38; i++) step(3'd1, 1, 0, 32'hFFFF_FFF0 | ($urandom & 32'hF), '0, '0, "");
    step(3'd4, 1, 0, $urandom, '0, '0, "");
    step(3'd5, 1, 0, $urandom, '0, '0, "");
    step(3'd4, 0, 1, 0, '0, '0, "R9 mask readback");
    step(3'd0, 1, 0, 32'h0, '0, '0, "");
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: step(3'd2, 0, 1, 0, NTX'($urandom & $urandom), NRX'($urandom & $urandom), "R7 tx flags");
        1: step(3'd3, 0, 1, 0, NTX'($urandom & $urandom), NRX'($urandom & $urandom), "R7 rx flags");
        2: step(3'd1, 0, 1, 0, NTX'($urandom & $urandom), NRX'($urandom & $urandom), "R5 live count");
        default: rand_ev(1, "");
      endcase
    end
    rd_all(0, "R5 sweep");
    // freeze, replay, live strobes behind replay
    step(3'd0, 1, 0, 32'h0000_0200, '0, '0, "");
    rand_ev(10, "");
    for (int i = 0; i < 5; i++) step(3'd1, 0, 1, 0, NTX'($urandom), NRX'($urandom), "R10 frozen read");
    step(3'd0, 1, 0, 32'h0, '0, '0, "");
    rand_ev(30, "");
    idle(20);
    rd_all(0, "R10 replay");
    // overflow
    step(3'd0, 1, 0, 32'h0000_0200, '0, '0, "");
    for (int i = 0; i < 20; i++) step(3'd0, 0, 0, 0, '1, '1, "");
    step(3'd0, 0, 1, 0, '0, '0, "R11 overflow bit");
    step(3'd0, 1, 0, 32'h0, '0, '0, "");
    idle(30);
    rd_all(0, "R11 after drain");
    step(3'd0, 0, 1, 0, '0, '0, "R11 sticky");
    step(3'd3, 0, 1, 0, '0, '0, "R8 rx final");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule